// File: doc/BRIEF.md
# ATA Task-File Register Front End

This block is the host-facing register file of an ATA channel that carries two devices. A simple synchronous bus reaches two windows: an 8-entry command window and a small control window. Each device keeps its own copy of the parameter registers, status and error. Writes to the parameter registers reach both copies together. The head register write also picks which device answers reads and takes commands.

Opcodes written to the command offset are decoded here. Short housekeeping commands are finished inside the block: recalibrate, standby, flush, diagnostic, and any command that must be aborted. Data-moving and configuration commands go to a separate transfer sequencer as a one-cycle start pulse that carries a kind code and the device number. The sequencer reports completion back through ok and abort strobes. The block also owns the channel interrupt line, which can be masked, and a soft reset driven from the control window.

Top module: `tfile_front`

## Requirements
- R1: Command-window writes at offsets 1..6 (features, sector count, sector number, cylinder low, cylinder high, head) update the copy in both devices. Reads at offsets 1..6 return error, count, sector, cylinder low, cylinder high and head of the selected device. Offset 0 reads 0 and ignores writes. `tf_params` shows the selected device as {features[47:40], count[39:32], sector[31:24], cyl_lo[23:16], cyl_hi[15:8], head[7:0]}.
- R2: A write at offset 6 selects device 1 when bit 4 of the data is 1 and device 0 otherwise. Each device keeps its own status and error.
- R3: After reset the status is 0x50 (ready 0x40 | seek-complete 0x10), the other registers are 0, device 0 is selected, `irq` is low and `xfer_start` is low.
- R4: Reading status at command offset 7 clears `irq`. The control-window read at offset 2 returns the same status and leaves `irq` alone. Other control offsets read 0.
- R5: While bit 1 of the control register (written at control offset 2) is 1, `irq` cannot rise. Writing the register with bit 1 set drives `irq` low at the next edge.
- R6: A control-register write that takes bit 2 from 1 to 0 loads both devices with cylinder 0, sector 1, count 1, head 0, error 0x01 and status 0x50, and selects device 0.
- R7: An abort sets status 0x41 (ready | error bit 0x01) and error 0x04, and requests the interrupt. An ok completion sets status 0x50 and requests the interrupt. `done_ok` and `done_abort` act on the device given by the last `xfer_dev`.
- R8: When the selected device has no medium (`media_present` bit low), command-window reads return 0, a status read there leaves `irq` alone, and every command is aborted without a start pulse.
- R9: Any opcode not listed in R10 to R13 is aborted.
- R10: Opcode 0x10 clears both cylinder registers and the low head nibble. It then loads sector 0 when head bit 6 (LBA) is set and sector 1 otherwise, and completes ok.
- R11: Opcodes 0x94, 0xE0 and 0xE7 complete ok at once.
- R12: Opcode 0x90 applies the R6 values to both devices, selects device 0 and leaves `irq` unchanged.
- R13: The transfer opcodes give a one-cycle `xfer_start` in the cycle after the write, with `xfer_kind` and `xfer_dev` = selected device. The kinds are 0x20/0x21→0, 0x30/0x31→1, 0xC4→2, 0xC5→3, 0xC6→4, 0x91→5, 0xEC→6. The device status becomes 0x80 (busy) and `irq` is unchanged.
- R14: If an interrupt request and a command-offset status read fall in the same cycle, the request wins and `irq` ends high, unless it is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_cmd | input | 1 | Command window select |
| cs_ctl | input | 1 | Control window select |
| addr | input | 3 | Register offset within the window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (status read side effect) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational in the read cycle |
| media_present | input | 2 | Medium attached, one bit per device |
| done_ok | input | 1 | Sequencer finished without error |
| done_abort | input | 1 | Sequencer aborted |
| xfer_start | output | 1 | One-cycle start pulse to the sequencer |
| xfer_kind | output | 3 | Kind of the started command |
| xfer_dev | output | 1 | Device that owns the started command |
| tf_params | output | 48 | Parameter registers of the selected device |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions check the cycle-level rules on every clock. An unmasked interrupt request wins over a same-cycle status read. The interrupt never rises while the mask bit is set, and a mask write pulls it low. An abort always leaves status 0x41 and error 0x04. Soft reset and diagnostic leave the default values in place with device 0 selected. A command to an absent medium never produces a start pulse. Only the bench scenarios can show that both device copies stay coherent over long write sequences, that the opcode-to-kind map and the recalibrate sector rule are right, and that masked and unmasked requests interleave correctly with reads, soft resets and medium changes.

// File: rtl/tfile_pkg.sv
package tfile_pkg;

    localparam int NUM_DEV      = 2;
    localparam int DATA_W       = 8;
    localparam int OFS_W        = 3;
    localparam int HEAD_DEV_BIT = 4;
    localparam int HEAD_LBA_BIT = 6;
    localparam int DC_MASK_BIT  = 1;
    localparam int DC_SRST_BIT  = 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    localparam ofs_t OFS_DATA   = 3'd0;
    localparam ofs_t OFS_FEAT   = 3'd1;
    localparam ofs_t OFS_COUNT  = 3'd2;
    localparam ofs_t OFS_SECTOR = 3'd3;
    localparam ofs_t OFS_CYL_LO = 3'd4;
    localparam ofs_t OFS_CYL_HI = 3'd5;
    localparam ofs_t OFS_HEAD   = 3'd6;
    localparam ofs_t OFS_CMD    = 3'd7;
    localparam ofs_t OFS_CTL    = 3'd2;

    localparam byte_t ST_BSY  = 8'h80;
    localparam byte_t ST_DRDY = 8'h40;
    localparam byte_t ST_DSC  = 8'h10;
    localparam byte_t ST_ERR  = 8'h01;
    localparam byte_t ST_IDLE = ST_DRDY | ST_DSC;
    localparam byte_t ST_FAIL = ST_DRDY | ST_ERR;
    localparam byte_t ER_ABRT = 8'h04;
    localparam byte_t ER_DIAG = 8'h01;

    typedef struct packed {
        byte_t status;
        byte_t error;
        byte_t features;
        byte_t count;
        byte_t sector;
        byte_t cyl_lo;
        byte_t cyl_hi;
        byte_t head;
    } devregs_t;

    typedef enum logic [2:0] {
        XK_READ        = 3'd0,
        XK_WRITE       = 3'd1,
        XK_READ_MULTI  = 3'd2,
        XK_WRITE_MULTI = 3'd3,
        XK_SET_MULTI   = 3'd4,
        XK_SET_GEOM    = 3'd5,
        XK_IDENTIFY    = 3'd6
    } xfer_kind_e;

    typedef enum logic [2:0] {
        OC_XFER,
        OC_DONE,
        OC_RECAL,
        OC_DIAG,
        OC_BAD
    } op_class_e;

    typedef struct packed {
        op_class_e  cls;
        xfer_kind_e kind;
    } op_dec_t;

    function automatic op_dec_t decode_opcode(input byte_t op);
        op_dec_t d;
        d.cls  = OC_BAD;
        d.kind = XK_READ;
        case (op)
            8'h20, 8'h21: begin d.cls = OC_XFER; d.kind = XK_READ;        end
            8'h30, 8'h31: begin d.cls = OC_XFER; d.kind = XK_WRITE;       end
            8'hC4:        begin d.cls = OC_XFER; d.kind = XK_READ_MULTI;  end
            8'hC5:        begin d.cls = OC_XFER; d.kind = XK_WRITE_MULTI; end
            8'hC6:        begin d.cls = OC_XFER; d.kind = XK_SET_MULTI;   end
            8'h91:        begin d.cls = OC_XFER; d.kind = XK_SET_GEOM;    end
            8'hEC:        begin d.cls = OC_XFER; d.kind = XK_IDENTIFY;    end
            8'h10:              d.cls = OC_RECAL;
            8'h90:              d.cls = OC_DIAG;
            8'h94, 8'hE0, 8'hE7: d.cls = OC_DONE;
            default:            d.cls = OC_BAD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tfile_devregs.sv
module tfile_devregs
    import tfile_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     prm_we,
    input  ofs_t     prm_ofs,
    input  byte_t    prm_val,
    input  logic     load_defaults,
    input  logic     mark_ok,
    input  logic     mark_abort,
    input  logic     mark_busy,
    input  logic     recal,
    output devregs_t regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs        <= '0;
            regs.status <= ST_IDLE;
        end else if (load_defaults) begin
            regs.cyl_lo <= '0;
            regs.cyl_hi <= '0;
            regs.head   <= '0;
            regs.sector <= 8'd1;
            regs.count  <= 8'd1;
            regs.error  <= ER_DIAG;
            regs.status <= ST_IDLE;
        end else begin
            if (prm_we) begin
                case (prm_ofs)
                    OFS_FEAT:   regs.features <= prm_val;
                    OFS_COUNT:  regs.count    <= prm_val;
                    OFS_SECTOR: regs.sector   <= prm_val;
                    OFS_CYL_LO: regs.cyl_lo   <= prm_val;
                    OFS_CYL_HI: regs.cyl_hi   <= prm_val;
                    OFS_HEAD:   regs.head     <= prm_val;
                    default: ;
                endcase
            end
            if (recal) begin
                regs.cyl_lo <= '0;
                regs.cyl_hi <= '0;
                regs.head   <= {regs.head[7:4], 4'h0};
                regs.sector <= regs.head[HEAD_LBA_BIT] ? 8'd0 : 8'd1;
            end
            if (mark_abort) begin
                regs.status <= ST_FAIL;
                regs.error  <= ER_ABRT;
            end else if (mark_ok) begin
                regs.status <= ST_IDLE;
            end else if (mark_busy) begin
                regs.status <= ST_BSY;
            end
        end
    end

    AST_ABORT_MARK: assert property (@(posedge clk) disable iff (rst)
        (mark_abort && !load_defaults) |=> (regs.status == ST_FAIL && regs.error == ER_ABRT)); // R7

    AST_DEFAULTS_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_defaults |=> (regs.count == 8'd1 && regs.sector == 8'd1 &&
                           regs.error == ER_DIAG && regs.status == ST_IDLE && regs.head == 8'd0)); // R6

endmodule

// File: rtl/tfile_irq.sv
module tfile_irq (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic blocked,
    input  logic drop,
    input  logic force_low,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (force_low) begin
            irq <= 1'b0;
        end else if (raise && !blocked) begin
            irq <= 1'b1;
        end else if (drop) begin
            irq <= 1'b0;
        end
    end

    AST_REQ_WINS: assert property (@(posedge clk) disable iff (rst)
        (raise && !blocked && !force_low) |=> irq); // R14

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
        force_low |=> !irq); // R5

endmodule

// File: rtl/tfile_front.sv
module tfile_front
    import tfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_cmd,
    input  logic                cs_ctl,
    input  logic [OFS_W-1:0]    addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_DEV-1:0]  media_present,
    input  logic                done_ok,
    input  logic                done_abort,
    output logic                xfer_start,
    output logic [2:0]          xfer_kind,
    output logic                xfer_dev,
    output logic [6*DATA_W-1:0] tf_params,
    output logic                irq
);

    logic       sel_q;
    logic       mask_q;
    logic       srst_q;
    logic       xstart_q;
    xfer_kind_e xkind_q;
    logic       xdev_q;

    devregs_t   dregs [NUM_DEV];
    devregs_t   cur;
    op_dec_t    dec;

    logic media_ok;
    logic cmd_wr, ctl_wr, dc_wr, prm_we, cmd_go;
    logic cmd_ok, cmd_abort, cmd_recal, cmd_diag, cmd_xfer;
    logic srst_fall, reset_all, stat_rd;
    logic irq_raise, irq_block, irq_force;

    assign cur      = dregs[sel_q];
    assign media_ok = media_present[sel_q];
    assign dec      = decode_opcode(wdata);

    assign cmd_wr = cs_cmd && wr_en;
    assign ctl_wr = cs_ctl && !cs_cmd && wr_en;
    assign dc_wr  = ctl_wr && (addr == OFS_CTL);
    assign prm_we = cmd_wr && (addr != OFS_DATA) && (addr != OFS_CMD);
    assign cmd_go = cmd_wr && (addr == OFS_CMD);

    assign cmd_abort = cmd_go && (!media_ok || dec.cls == OC_BAD);
    assign cmd_recal = cmd_go && media_ok && (dec.cls == OC_RECAL);
    assign cmd_ok    = cmd_go && media_ok && (dec.cls == OC_DONE || dec.cls == OC_RECAL);
    assign cmd_diag  = cmd_go && media_ok && (dec.cls == OC_DIAG);
    assign cmd_xfer  = cmd_go && media_ok && (dec.cls == OC_XFER);

    assign srst_fall = dc_wr && srst_q && !wdata[DC_SRST_BIT];
    assign reset_all = cmd_diag || srst_fall;

    assign stat_rd   = cs_cmd && rd_en && (addr == OFS_CMD) && media_ok;
    assign irq_raise = cmd_ok || cmd_abort || done_ok || done_abort;
    assign irq_block = dc_wr ? wdata[DC_MASK_BIT] : mask_q;
    assign irq_force = dc_wr && wdata[DC_MASK_BIT];

    genvar g;
    generate
        for (g = 0; g < NUM_DEV; g++) begin : g_dev
            logic is_sel;
            logic is_own;
            assign is_sel = (sel_q == 1'(g));
            assign is_own = (xdev_q == 1'(g));

            tfile_devregs u_regs (
                .clk           (clk),
                .rst           (rst),
                .prm_we        (prm_we),
                .prm_ofs       (addr),
                .prm_val       (wdata),
                .load_defaults (reset_all),
                .mark_ok       ((cmd_ok && is_sel) || (done_ok && is_own)),
                .mark_abort    ((cmd_abort && is_sel) || (done_abort && is_own)),
                .mark_busy     (cmd_xfer && is_sel),
                .recal         (cmd_recal && is_sel),
                .regs          (dregs[g])
            );
        end
    endgenerate

    tfile_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .raise     (irq_raise),
        .blocked   (irq_block),
        .drop      (stat_rd),
        .force_low (irq_force),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            mask_q   <= 1'b0;
            srst_q   <= 1'b0;
            xstart_q <= 1'b0;
            xkind_q  <= XK_READ;
            xdev_q   <= 1'b0;
        end else begin
            if (reset_all) begin
                sel_q <= 1'b0;
            end else if (prm_we && addr == OFS_HEAD) begin
                sel_q <= wdata[HEAD_DEV_BIT];
            end
            if (dc_wr) begin
                mask_q <= wdata[DC_MASK_BIT];
                srst_q <= wdata[DC_SRST_BIT];
            end
            xstart_q <= cmd_xfer;
            if (cmd_xfer) begin
                xkind_q <= dec.kind;
                xdev_q  <= sel_q;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && cs_cmd) begin
            if (media_ok) begin
                case (addr)
                    OFS_FEAT:   rdata = cur.error;
                    OFS_COUNT:  rdata = cur.count;
                    OFS_SECTOR: rdata = cur.sector;
                    OFS_CYL_LO: rdata = cur.cyl_lo;
                    OFS_CYL_HI: rdata = cur.cyl_hi;
                    OFS_HEAD:   rdata = cur.head;
                    OFS_CMD:    rdata = cur.status;
                    default:    rdata = '0;
                endcase
            end
        end else if (rd_en && cs_ctl && addr == OFS_CTL) begin
            rdata = cur.status;
        end
    end

    assign xfer_start = xstart_q;
    assign xfer_kind  = xkind_q;
    assign xfer_dev   = xdev_q;
    assign tf_params  = {cur.features, cur.count, cur.sector, cur.cyl_lo, cur.cyl_hi, cur.head};

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !mask_q); // R5

    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !irq_raise) |=> !irq); // R4

    AST_NOMEDIA_NOSTART: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && !media_ok) |=> !xfer_start); // R8

    AST_RESET_DEV0: assert property (@(posedge clk) disable iff (rst)
        reset_all |=> !sel_q); // R6

endmodule

// File: tb/tfile_front_test.sv
module tfile_front_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_cmd = 1'b0, cs_ctl = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  media = 2'b11;
    logic        done_ok = 1'b0, done_abort = 1'b0;
    logic        xfer_start, xfer_dev, irq;
    logic [2:0]  xfer_kind;
    logic [47:0] tf_params;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] m_st[2], m_er[2], m_ft[2], m_cnt[2], m_sec[2], m_cl[2], m_ch[2], m_hd[2];
    int   m_sel, m_xdev;
    logic [7:0] m_dc;
    logic m_irq;

    always #2 clk = ~clk;

    tfile_front uut (
        .clk(clk), .rst(rst), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .media_present(media), .done_ok(done_ok), .done_abort(done_abort),
        .xfer_start(xfer_start), .xfer_kind(xfer_kind), .xfer_dev(xfer_dev),
        .tf_params(tf_params), .irq(irq)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic m_defaults();
        for (int d = 0; d < 2; d++) begin
            m_cl[d] = 0; m_ch[d] = 0; m_hd[d] = 0;
            m_sec[d] = 1; m_cnt[d] = 1; m_er[d] = 8'h01; m_st[d] = 8'h50;
        end
        m_sel = 0;
    endtask

    task automatic m_req();
        if (!m_dc[1]) m_irq = 1'b1;
    endtask

    task automatic m_ok(input int d);
        m_st[d] = 8'h50;
        m_req();
    endtask

    task automatic m_abort(input int d);
        m_st[d] = 8'h41;
        m_er[d] = 8'h04;
        m_req();
    endtask

    function automatic logic [7:0] m_read_cmd(input int a);
        if (!media[m_sel]) return 8'h00;
        case (a)
            1: return m_er[m_sel];
            2: return m_cnt[m_sel];
            3: return m_sec[m_sel];
            4: return m_cl[m_sel];
            5: return m_ch[m_sel];
            6: return m_hd[m_sel];
            7: return m_st[m_sel];
            default: return 8'h00;
        endcase
    endfunction

    // irq level, alternate status and parameter view after every operation
    task automatic post(input string tag);
        chk({tag, " irq"}, {47'd0, irq}, {47'd0, m_irq});
        cs_ctl = 1; rd_en = 1; addr = 3'd2;
        #1;
        chk({tag, " alt-status"}, {40'd0, rdata}, {40'd0, m_st[m_sel]});
        chk({tag, " tf_params"}, tf_params,
            {m_ft[m_sel], m_cnt[m_sel], m_sec[m_sel], m_cl[m_sel], m_ch[m_sel], m_hd[m_sel]});
        @(negedge clk);
        cs_ctl = 0; rd_en = 0;
    endtask

    task automatic wr_cmd(input logic [2:0] a, input logic [7:0] v, input string tag);
        logic exp_s;
        logic [2:0] exp_k;
        int d;
        exp_s = 0; exp_k = 0;
        d = m_sel;
        if (a >= 1 && a <= 6) begin
            for (int i = 0; i < 2; i++) begin
                case (a)
                    1: m_ft[i] = v;
                    2: m_cnt[i] = v;
                    3: m_sec[i] = v;
                    4: m_cl[i] = v;
                    5: m_ch[i] = v;
                    default: m_hd[i] = v;
                endcase
            end
            if (a == 6) m_sel = v[4] ? 1 : 0;
        end else if (a == 7) begin
            if (!media[d]) m_abort(d);
            else begin
                case (v)
                    8'h20, 8'h21: begin exp_s = 1; exp_k = 0; end
                    8'h30, 8'h31: begin exp_s = 1; exp_k = 1; end
                    8'hC4: begin exp_s = 1; exp_k = 2; end
                    8'hC5: begin exp_s = 1; exp_k = 3; end
                    8'hC6: begin exp_s = 1; exp_k = 4; end
                    8'h91: begin exp_s = 1; exp_k = 5; end
                    8'hEC: begin exp_s = 1; exp_k = 6; end
                    8'h10: begin
                        m_cl[d] = 0; m_ch[d] = 0;
                        m_hd[d] = m_hd[d] & 8'hF0;
                        m_sec[d] = m_hd[d][6] ? 8'd0 : 8'd1;
                        m_ok(d);
                    end
                    8'h94, 8'hE0, 8'hE7: m_ok(d);
                    8'h90: m_defaults();
                    default: m_abort(d);
                endcase
                if (exp_s) begin
                    m_st[d] = 8'h80;
                    m_xdev = d;
                end
            end
        end
        @(negedge clk);
        cs_cmd = 1; wr_en = 1; addr = a; wdata = v;
        @(negedge clk);
        cs_cmd = 0; wr_en = 0;
        if (a == 7) begin
            chk({tag, " xfer_start"}, {47'd0, xfer_start}, {47'd0, exp_s});
            if (exp_s) begin
                chk({tag, " xfer_kind"}, {45'd0, xfer_kind}, {45'd0, exp_k});
                chk({tag, " xfer_dev"}, {47'd0, xfer_dev}, 48'(d));
            end
        end
        post(tag);
    endtask

    task automatic wr_ctl(input logic [2:0] a, input logic [7:0] v, input string tag);
        if (a == 3'd2) begin
            if (m_dc[2] && !v[2]) m_defaults();
            if (v[1]) m_irq = 1'b0;
            m_dc = v;
        end
        @(negedge clk);
        cs_ctl = 1; wr_en = 1; addr = a; wdata = v;
        @(negedge clk);
        cs_ctl = 0; wr_en = 0;
        post(tag);
    endtask

    task automatic rd_cmd(input logic [2:0] a, input string tag);
        logic [7:0] e;
        e = m_read_cmd(a);
        @(negedge clk);
        cs_cmd = 1; rd_en = 1; addr = a;
        #1;
        chk({tag, " read"}, {40'd0, rdata}, {40'd0, e});
        if (a == 7 && media[m_sel]) m_irq = 1'b0;
        @(negedge clk);
        cs_cmd = 0; rd_en = 0;
        post(tag);
    endtask

    task automatic rd_ctl(input logic [2:0] a, input string tag);
        logic [7:0] e;
        e = (a == 3'd2) ? m_st[m_sel] : 8'h00;
        @(negedge clk);
        cs_ctl = 1; rd_en = 1; addr = a;
        #1;
        chk({tag, " ctl read"}, {40'd0, rdata}, {40'd0, e});
        @(negedge clk);
        cs_ctl = 0; rd_en = 0;
        post(tag);
    endtask

    task automatic done(input bit ok, input string tag);
        if (ok) m_ok(m_xdev); else m_abort(m_xdev);
        @(negedge clk);
        done_ok = ok; done_abort = !ok;
        @(negedge clk);
        done_ok = 0; done_abort = 0;
        post(tag);
    endtask

    // status read and completion strobe in one cycle
    task automatic rd_stat_done(input bit ok, input string tag);
        logic [7:0] e;
        e = m_read_cmd(7);
        @(negedge clk);
        cs_cmd = 1; rd_en = 1; addr = 3'd7;
        done_ok = ok; done_abort = !ok;
        #1;
        chk({tag, " read"}, {40'd0, rdata}, {40'd0, e});
        if (media[m_sel]) m_irq = 1'b0;
        if (ok) m_ok(m_xdev); else m_abort(m_xdev);
        @(negedge clk);
        cs_cmd = 0; rd_en = 0; done_ok = 0; done_abort = 0;
        post(tag);
    endtask

    task automatic set_media(input logic [1:0] m);
        @(negedge clk);
        media = m;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [16];
        int seed;
        ops = '{8'h20, 8'h21, 8'h30, 8'h31, 8'hC4, 8'hC5, 8'hC6, 8'h91,
                8'hEC, 8'h10, 8'h90, 8'h94, 8'hE0, 8'hE7, 8'h55, 8'h00};
        seed = $urandom(32'h1F2E);
        for (int d = 0; d < 2; d++) begin
            m_st[d] = 8'h50; m_er[d] = 0; m_ft[d] = 0; m_cnt[d] = 0;
            m_sec[d] = 0; m_cl[d] = 0; m_ch[d] = 0; m_hd[d] = 0;
        end
        m_sel = 0; m_xdev = 0; m_dc = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R3 reset state
        chk("R3 xfer_start", {47'd0, xfer_start}, 48'd0);
        post("R3");
        rd_cmd(3'd7, "R3");
        rd_cmd(3'd2, "R3");

        // R1 broadcast writes, R2 selection
        wr_cmd(3'd2, 8'h5A, "R1");
        wr_cmd(3'd3, 8'h21, "R1");
        wr_cmd(3'd1, 8'h3C, "R1");
        rd_cmd(3'd2, "R1");
        wr_cmd(3'd6, 8'h10, "R2");
        rd_cmd(3'd2, "R1");
        rd_cmd(3'd3, "R1");
        wr_cmd(3'd0, 8'hFF, "R1");
        rd_cmd(3'd0, "R1");

        // R8 absent medium on device 1
        set_media(2'b01);
        rd_cmd(3'd2, "R8");
        wr_cmd(3'd7, 8'h94, "R8");
        rd_cmd(3'd7, "R8");
        wr_cmd(3'd7, 8'h20, "R8");
        set_media(2'b11);
        wr_cmd(3'd6, 8'h00, "R2");
        rd_cmd(3'd7, "R4");
        wr_cmd(3'd6, 8'h10, "R2");
        rd_ctl(3'd2, "R2");
        wr_cmd(3'd6, 8'h00, "R2");

        // R11, R4
        wr_cmd(3'd7, 8'h94, "R11");
        rd_ctl(3'd2, "R4");
        rd_ctl(3'd1, "R4");
        rd_cmd(3'd7, "R4");
        wr_cmd(3'd7, 8'hE0, "R11");
        wr_cmd(3'd7, 8'hE7, "R11");
        rd_cmd(3'd7, "R4");

        // R9
        wr_cmd(3'd7, 8'h55, "R9");
        rd_cmd(3'd1, "R9");

        // R10 CHS then LBA
        wr_cmd(3'd6, 8'h0B, "R10");
        wr_cmd(3'd4, 8'h12, "R10");
        wr_cmd(3'd5, 8'h34, "R10");
        wr_cmd(3'd3, 8'h09, "R10");
        wr_cmd(3'd7, 8'h10, "R10");
        rd_cmd(3'd3, "R10");
        rd_cmd(3'd4, "R10");
        rd_cmd(3'd6, "R10");
        wr_cmd(3'd6, 8'h4F, "R10");
        wr_cmd(3'd7, 8'h10, "R10");
        rd_cmd(3'd3, "R10");
        rd_cmd(3'd6, "R10");

        // R5 masking
        rd_cmd(3'd7, "R4");
        wr_ctl(3'd2, 8'h02, "R5");
        wr_cmd(3'd7, 8'hE7, "R5");
        wr_ctl(3'd2, 8'h00, "R5");
        wr_cmd(3'd7, 8'hE7, "R5");
        wr_ctl(3'd2, 8'h02, "R5");
        wr_ctl(3'd2, 8'h00, "R5");

        // R6 soft reset
        wr_ctl(3'd2, 8'h04, "R6");
        wr_cmd(3'd6, 8'h1A, "R6");
        wr_cmd(3'd2, 8'h77, "R6");
        wr_ctl(3'd2, 8'h00, "R6");
        rd_cmd(3'd2, "R6");
        rd_cmd(3'd3, "R6");
        rd_cmd(3'd1, "R6");
        rd_cmd(3'd6, "R6");

        // R12 diagnostic
        wr_cmd(3'd2, 8'h33, "R12");
        wr_cmd(3'd6, 8'h10, "R12");
        rd_cmd(3'd7, "R12");
        wr_cmd(3'd7, 8'h90, "R12");
        rd_cmd(3'd2, "R12");
        rd_cmd(3'd1, "R12");

        // R13 transfer handoff, R7 completions
        for (int i = 0; i < 9; i++) begin
            wr_cmd(3'd6, (i % 2) ? 8'h10 : 8'h00, "R13");
            wr_cmd(3'd7, ops[i], "R13");
            done(i % 3 != 0, "R7");
            rd_cmd(3'd1, "R7");
        end

        // R14 request against status read
        wr_cmd(3'd7, 8'h20, "R14");
        rd_stat_done(1'b1, "R14");
        wr_cmd(3'd7, 8'hEC, "R14");
        rd_stat_done(1'b0, "R14");
        rd_cmd(3'd7, "R14");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            k = $urandom % 9;
            case (k)
                0, 1: wr_cmd(3'($urandom % 7), 8'($urandom), "RND R1");
                2:    wr_cmd(3'd7, ((($urandom % 8) == 0) ? 8'($urandom) : ops[$urandom % 16]), "RND R13");
                3:    wr_ctl(((($urandom % 4) == 0) ? 3'($urandom) : 3'd2), 8'($urandom & 32'h06), "RND R6");
                4:    rd_cmd(3'd7, "RND R4");
                5:    done(1'($urandom), "RND R7");
                6:    set_media(((($urandom % 3) == 0) ? 2'($urandom) : 2'b11));
                7:    rd_cmd(3'($urandom), "RND R1");
                default: rd_stat_done(1'($urandom), "RND R14");
            endcase
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule